// File: doc/BRIEF.md
# Three-Axis Sample Holding Bank with Data-Ready and Pair Locking

This block holds the latest three-axis acceleration sample on the register side of a sensor. Each axis is kept as a 16-bit two's-complement word. The word is left-aligned, and any resolution below 16 bits is padded with zeros in its least significant bits. A host reads the words one byte at a time through a simple address and read-strobe port. The serial bus front end that produces that port sits outside this block.

A new-sample strobe loads all three axis values together and raises a data-ready flag. Reading any axis high byte clears the flag. The flag can also be sent to two interrupt pins, each with its own enable. The pins then either follow the flag (latched) or give a fixed-width pulse for each new sample (pulsed), and the width of that pulse is a parameter counted in clock cycles.

With pair locking enabled, an axis whose first byte has been read is held until its other byte is read. A sample that arrives during the hold goes to a per-axis shadow register and takes effect once the pair has been completed. Each axis is locked on its own, so different axes may show different samples.

Top module: `accel_out_bank`

## Requirements
- R1: After reset every readable byte is 0x00, the data-ready flag is 0, and both interrupt pins are 0.
- R2: The byte on `rd_data` follows `rd_addr` in the same cycle. X low/high sit at 0x28/0x29, Y at 0x2A/0x2B and Z at 0x2C/0x2D. The RES_W-bit sample occupies bits 15 down to 16-RES_W of the word, with zeros below. Any address that is not mapped returns 0x00.
- R3: Address 0x27 returns the data-ready flag in bit 0, with bits 7..1 at zero.
- R4: The data-ready flag rises in the cycle after `smp_valid`. A read strobe at 0x29, 0x2B or 0x2D clears it at the next edge. A set and a clear in the same cycle leave it set. Reads of low bytes or of 0x27 do not change it.
- R5: When `pulse_mode` is 0, each enabled interrupt pin equals the data-ready flag.
- R6: When `pulse_mode` is 1, each enabled pin is high for exactly PULSE_CYCLES cycles, starting the cycle after `smp_valid`. A new strobe restarts the count. The data-ready flag stays latched as in R4.
- R7: `route_int1` and `route_int2` gate the two pins independently. A pin whose enable is 0 stays at 0.
- R8: When `bdu_en` is 0, every strobe updates all three axes at the next edge.
- R9: When `bdu_en` is 1, an axis whose low or high byte has been read keeps its word until the other byte of the same axis is read. This includes a strobe that arrives in the same cycle as the first read.
- R10: Under R9, the newest sample that arrives during the hold becomes visible in the cycle after the completing read. A strobe that arrives in the completing cycle itself is loaded directly.
- R11: Under R9, axes that are not held keep updating with every strobe.
- R12: When `bdu_en` drops while a shadow sample is pending, that sample becomes visible at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | New sample set strobe |
| smp_x | input | RES_W | X sample, right-justified |
| smp_y | input | RES_W | Y sample, right-justified |
| smp_z | input | RES_W | Z sample, right-justified |
| bdu_en | input | 1 | Pair locking enable |
| pulse_mode | input | 1 | 1: pulsed interrupt, 0: latched |
| route_int1 | input | 1 | Send data-ready to pin 1 |
| route_int2 | input | 1 | Send data-ready to pin 2 |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | ADDR_W | Byte read address |
| rd_data | output | 8 | Byte read data |
| drdy | output | 1 | Data-ready status flag |
| int1_o | output | 1 | Interrupt pin 1 |
| int2_o | output | 1 | Interrupt pin 2 |

## Verification
The assertions assume that the configuration inputs are stable around a strobe. They also assume that a read strobe carries one address per cycle, so a low and a high byte of the same axis are never read in the same cycle. The stimulus changes the mode and enable inputs only on falling edges and between scenarios, and issues one byte read per cycle. The lock scenarios place strobes in the cycle of the first read, during the hold, and in the completing cycle, because the ordering rules of the shadow register are decided in those cycles.

// File: rtl/accel_out_pkg.sv
package accel_out_pkg;
   localparam int SAMPLE_W = 16;
   localparam int BYTE_W   = 8;
   typedef logic [SAMPLE_W-1:0] sample_t;
   typedef logic [BYTE_W-1:0]   byte_t;
endpackage

// File: rtl/axis_slot.sv
module axis_slot
   import accel_out_pkg::*;
#(
   parameter int RES_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bdu_en,
   input  logic             smp_valid,
   input  logic [RES_W-1:0] smp,
   input  logic             rd_lo,
   input  logic             rd_hi,
   output sample_t          vis
);
   localparam int PAD_W = SAMPLE_W - RES_W;

   if (RES_W < BYTE_W || RES_W > SAMPLE_W) begin : g_bad_res
      $error("axis_slot: RES_W out of range");
   end

   logic             lo_seen, hi_seen, pend;
   logic [RES_W-1:0] shad;
   sample_t          vis_q, smp_pad, shad_pad;
   logic             pair_done, hold;

   if (PAD_W == 0) begin : g_full
      assign smp_pad  = smp;
      assign shad_pad = shad;
   end else begin : g_pad
      assign smp_pad  = {smp,  {PAD_W{1'b0}}};
      assign shad_pad = {shad, {PAD_W{1'b0}}};
   end

   assign pair_done = bdu_en && ((rd_lo && hi_seen) || (rd_hi && lo_seen));
   assign hold      = bdu_en && !pair_done && (lo_seen || hi_seen || rd_lo || rd_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_seen <= 1'b0;
         hi_seen <= 1'b0;
      end else if (!bdu_en || pair_done) begin
         lo_seen <= 1'b0;
         hi_seen <= 1'b0;
      end else begin
         lo_seen <= lo_seen | rd_lo;
         hi_seen <= hi_seen | rd_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_q <= '0;
         shad  <= '0;
         pend  <= 1'b0;
      end else if (smp_valid && !hold) begin
         vis_q <= smp_pad;
         pend  <= 1'b0;
      end else if (smp_valid) begin
         shad  <= smp;
         pend  <= 1'b1;
      end else if (pend && !hold) begin
         vis_q <= shad_pad;
         pend  <= 1'b0;
      end
   end

   assign vis = vis_q;

   AST_HELD_PAIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bdu_en && (lo_seen || hi_seen) && !rd_lo && !rd_hi) |=> $stable(vis_q)); // R9
   AST_UNLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bdu_en && smp_valid) |=> (vis_q == $past(smp_pad))); // R8
   AST_SHADOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && pend && !smp_valid) |=> (vis_q == $past(shad_pad))); // R10
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl #(
   parameter int PULSE_CYCLES = 1400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic hi_read,
   input  logic pulse_mode,
   input  logic route1,
   input  logic route2,
   output logic drdy,
   output logic int1,
   output logic int2
);
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("drdy_ctrl: PULSE_CYCLES must be at least 1");
   end

   logic             flag_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_on, src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (smp_valid) flag_q <= 1'b1;
      else if (hi_read)   flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (smp_valid)      cnt_q <= CNT_W'(PULSE_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_on = (cnt_q != '0);
   assign src      = pulse_mode ? pulse_on : flag_q;
   assign drdy     = flag_q;
   assign int1     = route1 & src;
   assign int2     = route2 & src;

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> flag_q); // R4
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_read && !smp_valid) |=> !flag_q); // R4
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> pulse_on); // R6
   AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_on && !smp_valid) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/byte_read_mux.sv
module byte_read_mux
   import accel_out_pkg::*;
#(
   parameter int NUM_AXES    = 3,
   parameter int ADDR_W      = 8,
   parameter int STATUS_ADDR = 'h27,
   parameter int BASE_ADDR   = 'h28
) (
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [NUM_AXES*SAMPLE_W-1:0] vis_flat,
   input  logic                         drdy,
   output byte_t                        rd_data,
   output logic [NUM_AXES-1:0]          rd_lo,
   output logic [NUM_AXES-1:0]          rd_hi
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

   if (BASE_ADDR + 2*NUM_AXES > (1 << ADDR_W)) begin : g_bad_map
      $error("byte_read_mux: map exceeds address space");
   end

   byte_t [NUM_AXES-1:0] lo_b, hi_b;
   logic  [NUM_AXES-1:0] hit_lo, hit_hi;

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR + 2*a);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2*a + 1);
      assign lo_b[a]   = vis_flat[a*SAMPLE_W +: BYTE_W];
      assign hi_b[a]   = vis_flat[a*SAMPLE_W + BYTE_W +: BYTE_W];
      assign hit_lo[a] = (rd_addr == LO_A);
      assign hit_hi[a] = (rd_addr == HI_A);
      assign rd_lo[a]  = rd_en & hit_lo[a];
      assign rd_hi[a]  = rd_en & hit_hi[a];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == STAT_A) rd_data = {{(BYTE_W-1){1'b0}}, drdy};
      for (int a = 0; a < NUM_AXES; a++) begin
         if (hit_lo[a]) rd_data = lo_b[a];
         if (hit_hi[a]) rd_data = hi_b[a];
      end
   end
endmodule

// File: rtl/accel_out_bank.sv
module accel_out_bank
   import accel_out_pkg::*;
#(
   parameter int RES_W        = 14,
   parameter int PULSE_CYCLES = 1400,
   parameter int ADDR_W       = 8,
   parameter int STATUS_ADDR  = 'h27,
   parameter int BASE_ADDR    = 'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [RES_W-1:0]  smp_x,
   input  logic [RES_W-1:0]  smp_y,
   input  logic [RES_W-1:0]  smp_z,
   input  logic              bdu_en,
   input  logic              pulse_mode,
   input  logic              route_int1,
   input  logic              route_int2,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              drdy,
   output logic              int1_o,
   output logic              int2_o
);
   localparam int NUM_AXES = 3;

   logic [NUM_AXES-1:0][RES_W-1:0] smp_arr;
   logic [NUM_AXES*SAMPLE_W-1:0]   vis_flat;
   logic [NUM_AXES-1:0]            rd_lo, rd_hi;
   logic                           hi_read;

   assign smp_arr = {smp_z, smp_y, smp_x};
   assign hi_read = |rd_hi;

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_slot
      axis_slot #(.RES_W(RES_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .bdu_en    (bdu_en),
         .smp_valid (smp_valid),
         .smp       (smp_arr[a]),
         .rd_lo     (rd_lo[a]),
         .rd_hi     (rd_hi[a]),
         .vis       (vis_flat[a*SAMPLE_W +: SAMPLE_W])
      );
   end

   drdy_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_drdy (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .hi_read    (hi_read),
      .pulse_mode (pulse_mode),
      .route1     (route_int1),
      .route2     (route_int2),
      .drdy       (drdy),
      .int1       (int1_o),
      .int2       (int2_o)
   );

   byte_read_mux #(
      .NUM_AXES    (NUM_AXES),
      .ADDR_W      (ADDR_W),
      .STATUS_ADDR (STATUS_ADDR),
      .BASE_ADDR   (BASE_ADDR)
   ) u_mux (
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .vis_flat (vis_flat),
      .drdy     (drdy),
      .rd_data  (rd_data),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi)
   );

   AST_PIN1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !route_int1 |-> !int1_o); // R7
   AST_PIN2_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !route_int2 |-> !int2_o); // R7
   AST_LATCHED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode && route_int1) |-> (int1_o == drdy)); // R5
endmodule

// File: tb/sim_accel_out_bank.sv
module sim_accel_out_bank;
   localparam int CLK_NS = 10;
   localparam int RES   = 14;
   localparam int PW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [RES-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
   logic bdu_en = 1'b0, pulse_mode = 1'b0, route_int1 = 1'b1, route_int2 = 1'b1;
   logic rd_en = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic drdy, int1_o, int2_o;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_NS/2) clk = ~clk;

   accel_out_bank #(.RES_W(RES), .PULSE_CYCLES(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
      .bdu_en(bdu_en), .pulse_mode(pulse_mode),
      .route_int1(route_int1), .route_int2(route_int2),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .drdy(drdy), .int1_o(int1_o), .int2_o(int2_o)
   );

   // behavioural reference state
   int m_word[3];
   int m_next[3];
   bit m_waiting[3];
   bit m_got_lo[3], m_got_hi[3];
   bit m_ready;
   int m_pulse_left;

   function automatic int widen(logic [RES-1:0] s);
      return (int'(s) * (1 << (16 - RES))) & 16'hFFFF;
   endfunction

   function automatic logic [7:0] ref_byte(logic [7:0] a);
      if (a == 8'h27) return {7'b0, m_ready};
      for (int k = 0; k < 3; k++) begin
         if (int'(a) == 'h28 + 2*k) return 8'(m_word[k] & 'hFF);
         if (int'(a) == 'h29 + 2*k) return 8'((m_word[k] >> 8) & 'hFF);
      end
      return 8'h00;
   endfunction

   function automatic bit ref_pin(bit route);
      if (!route) return 1'b0;
      if (pulse_mode) return m_pulse_left > 0;
      return m_ready;
   endfunction

   task automatic ref_advance();
      logic [RES-1:0] inval[3];
      bit any_hi;
      inval[0] = smp_x; inval[1] = smp_y; inval[2] = smp_z;
      any_hi = 1'b0;
      for (int k = 0; k < 3; k++) begin
         bit lo_now, hi_now, finished, frozen;
         lo_now = rd_en && (int'(rd_addr) == 'h28 + 2*k);
         hi_now = rd_en && (int'(rd_addr) == 'h29 + 2*k);
         if (hi_now) any_hi = 1'b1;
         finished = bdu_en && ((lo_now && m_got_hi[k]) || (hi_now && m_got_lo[k]));
         frozen = bdu_en && !finished && (m_got_lo[k] || m_got_hi[k] || lo_now || hi_now);
         if (smp_valid) begin
            if (frozen) begin m_next[k] = widen(inval[k]); m_waiting[k] = 1'b1; end
            else begin m_word[k] = widen(inval[k]); m_waiting[k] = 1'b0; end
         end else if (m_waiting[k] && !frozen) begin
            m_word[k] = m_next[k]; m_waiting[k] = 1'b0;
         end
         if (!bdu_en || finished) begin m_got_lo[k] = 1'b0; m_got_hi[k] = 1'b0; end
         else begin
            if (lo_now) m_got_lo[k] = 1'b1;
            if (hi_now) m_got_hi[k] = 1'b1;
         end
      end
      if (smp_valid) m_ready = 1'b1;
      else if (any_hi) m_ready = 1'b0;
      if (smp_valid) m_pulse_left = PW;
      else if (m_pulse_left > 0) m_pulse_left--;
   endtask

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare all outputs, then let one clock edge pass; called at falling edges
   task automatic cyc(string tag);
      #1;
      check(tag, "rd_data", rd_data, ref_byte(rd_addr));
      check(tag, "drdy", {7'b0, drdy}, {7'b0, m_ready});
      check(tag, "int1", {7'b0, int1_o}, {7'b0, ref_pin(route_int1)});
      check(tag, "int2", {7'b0, int2_o}, {7'b0, ref_pin(route_int2)});
      @(posedge clk);
      if (rst_n) ref_advance();
      @(negedge clk);
      smp_valid = 1'b0;
      rd_en = 1'b0;
   endtask

   task automatic strobe(string tag, logic [RES-1:0] x, logic [RES-1:0] y, logic [RES-1:0] z);
      smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
      cyc(tag);
   endtask

   task automatic rd(string tag, logic [7:0] a);
      rd_en = 1'b1; rd_addr = a;
      cyc(tag);
   endtask

   task automatic rd_strobe(string tag, logic [7:0] a, logic [RES-1:0] x, logic [RES-1:0] y, logic [RES-1:0] z);
      rd_en = 1'b1; rd_addr = a;
      smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
      cyc(tag);
   endtask

   task automatic peek(string tag, logic [7:0] a);
      rd_addr = a;
      cyc(tag);
   endtask

   initial begin
      #(CLK_NS * 200000);
      miscompares++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         m_word[k] = 0; m_next[k] = 0; m_waiting[k] = 0; m_got_lo[k] = 0; m_got_hi[k] = 0;
      end
      m_ready = 0; m_pulse_left = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state over the whole map
      for (int a = 'h27; a <= 'h2D; a++) peek("R1", 8'(a));

      // R2 R8: mapping, left alignment, unlocked load
      strobe("R8", 14'h3FFF, 14'h0001, 14'h2000);
      for (int a = 'h28; a <= 'h2D; a++) peek("R2", 8'(a));
      peek("R2", 8'h30);
      peek("R2", 8'h26);

      // R3 R4: flag behaviour
      rd("R4", 8'h28);
      rd("R3", 8'h27);
      peek("R3", 8'h27);
      rd("R4", 8'h2B);
      peek("R3", 8'h27);
      strobe("R4", 14'h0123, 14'h1234, 14'h2345);
      rd_strobe("R4", 8'h2D, 14'h0AAA, 14'h1555, 14'h0F0F);
      peek("R4", 8'h27);
      rd("R4", 8'h29);

      // R5 R7: latched pins with independent routing
      route_int2 = 1'b0;
      strobe("R7", 14'h0010, 14'h0020, 14'h0030);
      peek("R5", 8'h28);
      rd("R5", 8'h2B);
      peek("R7", 8'h27);
      route_int1 = 1'b0; route_int2 = 1'b1;
      strobe("R7", 14'h0011, 14'h0021, 14'h0031);
      peek("R7", 8'h27);
      rd("R5", 8'h29);
      route_int1 = 1'b1;

      // R6: pulsed pins, flag still latched, retrigger
      pulse_mode = 1'b1;
      @(negedge clk);
      strobe("R6", 14'h0100, 14'h0200, 14'h0300);
      for (int i = 0; i < PW + 3; i++) peek("R6", 8'h27);
      strobe("R6", 14'h0101, 14'h0201, 14'h0301);
      peek("R6", 8'h27);
      peek("R6", 8'h27);
      strobe("R6", 14'h0102, 14'h0202, 14'h0302);
      for (int i = 0; i < PW + 2; i++) peek("R6", 8'h27);
      rd("R6", 8'h2D);
      pulse_mode = 1'b0;

      // R9 R10 R11: pair locking
      bdu_en = 1'b1;
      @(negedge clk);
      strobe("R9", 14'h1111, 14'h2222, 14'h3333);
      rd("R9", 8'h2A);
      strobe("R11", 14'h0444, 14'h0555, 14'h0666);
      peek("R11", 8'h28);
      peek("R11", 8'h29);
      peek("R9", 8'h2A);
      strobe("R10", 14'h0777, 14'h0888, 14'h0999);
      rd("R9", 8'h2B);
      peek("R10", 8'h2A);
      peek("R10", 8'h2B);
      // first read in the same cycle as a strobe
      rd_strobe("R9", 8'h2D, 14'h1ABC, 14'h1BCD, 14'h1CDE);
      peek("R9", 8'h2C);
      peek("R9", 8'h2D);
      // completing read together with a strobe loads directly
      rd_strobe("R10", 8'h2C, 14'h2468, 14'h1357, 14'h3579);
      peek("R10", 8'h2C);
      peek("R10", 8'h2D);
      // repeated read of one byte keeps the hold
      rd("R9", 8'h28);
      rd("R9", 8'h28);
      strobe("R9", 14'h0F00, 14'h00F0, 14'h000F);
      rd("R9", 8'h28);
      rd("R10", 8'h29);
      peek("R10", 8'h28);

      // R12: leaving lock mode releases a pending shadow
      rd("R12", 8'h2C);
      strobe("R12", 14'h3001, 14'h3002, 14'h3003);
      peek("R12", 8'h2D);
      bdu_en = 1'b0;
      peek("R12", 8'h2D);
      peek("R12", 8'h2C);
      peek("R12", 8'h2D);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule